// File: doc/BRIEF.md
# Hardware Semaphore Mailbox Channel

This block is one inter-processor communication channel on a simple 32-bit register bus. Several bus masters share it. A master claims the channel's lock by reading the acquire register. If the lock is free, that read succeeds and takes the lock as a side effect. The channel then records who holds the lock: the privilege level, the security state, the protection context and the master identifier of the winning access. A later read by another master fails and returns the recorded owner. A write of any value to the release register frees the lock.

Besides the lock, the channel holds two shared 32-bit data words for passing messages. It also drives two 16-bit event vectors, one for release events and one for notify events, toward up to 16 interrupt structures. Each event bit is a one-cycle pulse. A release write raises release events only while the lock is actually held. A notify write raises notify events unconditionally.

Register map (byte offsets): acquire 0x00, release 0x04, notify 0x08, data word 0 at 0x0C, data word 1 at 0x10, lock status 0x1C. Other offsets read as zero and ignore writes.

Top module: `sem_mailbox`

## Requirements
- R1: After reset the lock is free, the status register reads 0, both data words read 0 and both event vectors are 0.
- R2: A read of 0x00 while the lock is free returns bit 31 = 1 together with the current access attributes: privilege in bit 0, security in bit 1, protection context in bits 11:4 and master ID in bits 27:16. All other bits are 0. The lock is held from the next cycle on.
- R3: A read of 0x00 while the lock is held returns bit 31 = 0 with the stored owner attributes in the R2 layout. The stored attributes are not changed.
- R4: A read of 0x1C returns the held flag in bit 31 and the stored owner attributes in the R2 layout, and does not change the lock.
- R5: Any write to 0x04 frees the lock from the next cycle, whatever the write data.
- R6: A write to 0x04 while the lock is held makes `release_evt` equal write-data bits 15:0 for exactly the one cycle after the write. A write to 0x04 while the lock is free leaves `release_evt` at 0.
- R7: A write to 0x08 makes `notify_evt` equal write-data bits 15:0 for exactly the one cycle after the write, whether or not the lock is held. At all other times `notify_evt` is 0.
- R8: Reads of 0x04 and 0x08 return 0.
- R9: Offsets 0x0C and 0x10 are independent 32-bit read/write storage words.
- R10: Writes to 0x00 and 0x1C have no effect on the lock or the stored attributes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| attr_priv | input | 1 | Access is privileged (1) or user (0) |
| attr_nsec | input | 1 | Access is non-secure (1) or secure (0) |
| attr_pctx | input | 8 | Protection context of the access |
| attr_mid | input | 12 | Bus master identifier of the access |
| release_evt | output | 16 | One-cycle release event pulses, one bit per interrupt structure |
| notify_evt | output | 16 | One-cycle notify event pulses, one bit per interrupt structure |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. This matches a single-port bus, where an acquire and a release cannot collide. The assertions also assume that every address and attribute is a known value while a strobe is high. The bench drives each access for exactly one cycle on the falling edge and drops both strobes between accesses. It never raises both strobes together, so every check on the lock, the captured owner and the event pulses relies only on these conditions.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int PCTX_W = 8;
    localparam int MID_W  = 12;
    localparam int WORD_W = 32;

    // Byte offsets of the channel registers
    localparam logic [7:0] OFF_ACQUIRE = 8'h00;
    localparam logic [7:0] OFF_RELEASE = 8'h04;
    localparam logic [7:0] OFF_NOTIFY  = 8'h08;
    localparam logic [7:0] OFF_DATA0   = 8'h0C;
    localparam logic [7:0] OFF_STATUS  = 8'h1C;

    // Bit positions of the owner fields in the acquire and status words
    localparam int POS_PRIV = 0;
    localparam int POS_NSEC = 1;
    localparam int POS_PCTX = 4;
    localparam int POS_MID  = 16;
    localparam int POS_FLAG = 31;

    typedef struct packed {
        logic              priv;
        logic              nsec;
        logic [PCTX_W-1:0] pctx;
        logic [MID_W-1:0]  mid;
    } owner_t;

    function automatic logic [WORD_W-1:0] pack_owner(input logic flag, input owner_t o);
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_PRIV]                   = o.priv;
        w[POS_NSEC]                   = o.nsec;
        w[POS_PCTX +: PCTX_W]         = o.pctx;
        w[POS_MID  +: MID_W]          = o.mid;
        w[POS_FLAG]                   = flag;
        return w;
    endfunction

endpackage

// File: rtl/mbx_lock.sv
module mbx_lock
    import mbx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   acq_rd,
    input  logic   rel_wr,
    input  owner_t cur_attr,
    output logic   held,
    output owner_t owner
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= 1'b0;
            owner <= '0;
        end else if (rel_wr) begin
            held  <= 1'b0;
        end else if (acq_rd && !held) begin
            held  <= 1'b1;
            owner <= cur_attr;
        end
    end

endmodule

// File: rtl/mbx_evt_pulse.sv
module mbx_evt_pulse #(
    parameter int  NUM_EVT    = 16,
    parameter bit  NEED_LOCK  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic               lock_held,
    input  logic [NUM_EVT-1:0] bits,
    output logic [NUM_EVT-1:0] evt
);

    logic allow;

    generate
        if (NEED_LOCK) begin : g_gated
            assign allow = fire && lock_held;
        end else begin : g_free
            logic unused_lock;
            assign unused_lock = lock_held;
            assign allow = fire;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) evt <= '0;
        else     evt <= allow ? bits : '0;
    end

endmodule

// File: rtl/mbx_data.sv
module mbx_data #(
    parameter int ADDR_W   = 8,
    parameter int NUM_DATA = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [mbx_pkg::WORD_W-1:0] wdata,
    output logic [mbx_pkg::WORD_W-1:0] rdata,
    output logic                      hit
);
    import mbx_pkg::*;

    logic [WORD_W-1:0] word_q [NUM_DATA];
    logic [NUM_DATA-1:0] sel;

    generate
        for (genvar i = 0; i < NUM_DATA; i++) begin : g_word
            localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(int'(OFF_DATA0) + 4 * i);
            assign sel[i] = (addr == MY_OFF);
            always_ff @(posedge clk) begin
                if (rst)             word_q[i] <= '0;
                else if (wr && sel[i]) word_q[i] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (sel[i]) rdata = word_q[i];
        end
    end

    assign hit = |sel;

endmodule

// File: rtl/sem_mailbox.sv
module sem_mailbox
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_EVT  = 16,
    parameter int NUM_DATA = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               attr_priv,
    input  logic               attr_nsec,
    input  logic [7:0]         attr_pctx,
    input  logic [11:0]        attr_mid,
    output logic [NUM_EVT-1:0] release_evt,
    output logic [NUM_EVT-1:0] notify_evt
);

    localparam logic [ADDR_W-1:0] A_ACQ = ADDR_W'(OFF_ACQUIRE);
    localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(OFF_RELEASE);
    localparam logic [ADDR_W-1:0] A_NTF = ADDR_W'(OFF_NOTIFY);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STATUS);

    owner_t cur_attr;
    owner_t owner_attr;
    logic   lock_held;
    logic   acq_rd, rel_wr, ntf_wr;
    logic [WORD_W-1:0] data_rdata;
    logic   data_hit;

    assign cur_attr = '{priv: attr_priv, nsec: attr_nsec, pctx: attr_pctx, mid: attr_mid};

    assign acq_rd = bus_rd && (bus_addr == A_ACQ);
    assign rel_wr = bus_wr && (bus_addr == A_REL);
    assign ntf_wr = bus_wr && (bus_addr == A_NTF);

    mbx_lock u_lock (
        .clk      (clk),
        .rst      (rst),
        .acq_rd   (acq_rd),
        .rel_wr   (rel_wr),
        .cur_attr (cur_attr),
        .held     (lock_held),
        .owner    (owner_attr)
    );

    mbx_evt_pulse #(.NUM_EVT(NUM_EVT), .NEED_LOCK(1'b1)) u_rel_evt (
        .clk       (clk),
        .rst       (rst),
        .fire      (rel_wr),
        .lock_held (lock_held),
        .bits      (bus_wdata[NUM_EVT-1:0]),
        .evt       (release_evt)
    );

    mbx_evt_pulse #(.NUM_EVT(NUM_EVT), .NEED_LOCK(1'b0)) u_ntf_evt (
        .clk       (clk),
        .rst       (rst),
        .fire      (ntf_wr),
        .lock_held (lock_held),
        .bits      (bus_wdata[NUM_EVT-1:0]),
        .evt       (notify_evt)
    );

    mbx_data #(.ADDR_W(ADDR_W), .NUM_DATA(NUM_DATA)) u_data (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (data_rdata),
        .hit   (data_hit)
    );

    // Read mux; release and notify fall to the zero default
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_ACQ)
                bus_rdata = lock_held ? pack_owner(1'b0, owner_attr)
                                      : pack_owner(1'b1, cur_attr);
            else if (bus_addr == A_STS)
                bus_rdata = pack_owner(lock_held, owner_attr);
            else if (data_hit)
                bus_rdata = data_rdata;
        end
    end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker
    import mbx_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_EVT = 16
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [NUM_EVT-1:0] wbits,
    input logic [31:0]        bus_rdata,
    input logic               lock_held,
    input owner_t             owner,
    input logic [NUM_EVT-1:0] release_evt,
    input logic [NUM_EVT-1:0] notify_evt
);

    localparam logic [ADDR_W-1:0] A_ACQ = ADDR_W'(OFF_ACQUIRE);
    localparam logic [ADDR_W-1:0] A_REL = ADDR_W'(OFF_RELEASE);
    localparam logic [ADDR_W-1:0] A_NTF = ADDR_W'(OFF_NOTIFY);
    localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(OFF_STATUS);

    assert_acquire_takes_lock_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_ACQ && !lock_held) |-> (bus_rdata[31] ##1 lock_held));

    assert_busy_keeps_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_ACQ && lock_held) |-> (!bus_rdata[31] ##1 $stable(owner)));

    assert_status_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STS) |-> (bus_rdata[31] == lock_held));

    assert_release_frees_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_REL) |=> !lock_held);

    assert_no_release_when_free_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_REL && !lock_held) |=> (release_evt == '0));

    assert_release_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_REL) |=> (release_evt == '0));

    assert_notify_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_NTF) |=> (notify_evt == $past(wbits)));

    assert_notify_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_NTF) |=> (notify_evt == '0));

    assert_write_only_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (bus_addr == A_REL || bus_addr == A_NTF)) |-> (bus_rdata == '0));

    assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_addr == A_ACQ || bus_addr == A_STS)) |=> ($stable(lock_held) && $stable(owner)));

endmodule

bind sem_mailbox mbx_checker #(.ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .wbits       (bus_wdata[NUM_EVT-1:0]),
    .bus_rdata   (bus_rdata),
    .lock_held   (lock_held),
    .owner       (owner_attr),
    .release_evt (release_evt),
    .notify_evt  (notify_evt)
);

// File: tb/tb_sem_mailbox.sv
`timescale 1ns/1ps
module tb_sem_mailbox;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        attr_priv, attr_nsec;
    logic [7:0]  attr_pctx;
    logic [11:0] attr_mid;
    logic [15:0] release_evt, notify_evt;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    sem_mailbox dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .attr_priv(attr_priv),
        .attr_nsec(attr_nsec), .attr_pctx(attr_pctx), .attr_mid(attr_mid),
        .release_evt(release_evt), .notify_evt(notify_evt)
    );

    // Expected word built from the field layout in R2
    function automatic logic [31:0] exp_word(input logic flag, input logic p, input logic s,
                                             input logic [7:0] c, input logic [11:0] m);
        return {flag, 3'b000, m, 4'b0000, c, 2'b00, s, p};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_attr(input logic p, input logic s, input logic [7:0] c, input logic [11:0] m);
        attr_priv = p; attr_nsec = s; attr_pctx = c; attr_mid = m;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] wd,
                             output logic [15:0] rel, output logic [15:0] ntf);
        @(negedge clk);
        bus_addr = a; bus_wdata = wd; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rel = release_evt; ntf = notify_evt;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 status", 32'(0), 32'(0));
        bus_read(8'h1C, d); check("R1 status after reset", d, 32'h0);
        bus_read(8'h0C, d); check("R1 data0 after reset", d, 32'h0);
        bus_read(8'h10, d); check("R1 data1 after reset", d, 32'h0);
        check("R1 events idle", {release_evt, notify_evt}, 32'h0);
    endtask

    task automatic t_acquire_contention;
        logic [31:0] d;
        logic [15:0] r, n;
        set_attr(1'b1, 1'b0, 8'hA7, 12'h5C3);
        bus_read(8'h00, d); check("R2 acquire when free", d, exp_word(1, 1, 0, 8'hA7, 12'h5C3));
        bus_read(8'h1C, d); check("R4 status after win", d, exp_word(1, 1, 0, 8'hA7, 12'h5C3));
        set_attr(1'b0, 1'b1, 8'h3E, 12'hABC);
        bus_read(8'h00, d); check("R3 acquire when held", d, exp_word(0, 1, 0, 8'hA7, 12'h5C3));
        bus_read(8'h1C, d); check("R3 owner unchanged", d, exp_word(1, 1, 0, 8'hA7, 12'h5C3));
        bus_write(8'h00, 32'hFFFF_FFFF, r, n);
        bus_write(8'h1C, 32'h0000_0000, r, n);
        bus_read(8'h1C, d); check("R10 ro writes ignored", d, exp_word(1, 1, 0, 8'hA7, 12'h5C3));
    endtask

    task automatic t_write_only_regs;
        logic [31:0] d;
        bus_read(8'h04, d); check("R8 release reads zero", d, 32'h0);
        bus_read(8'h08, d); check("R8 notify reads zero", d, 32'h0);
    endtask

    task automatic t_notify_and_release;
        logic [31:0] d;
        logic [15:0] r, n;
        bus_write(8'h08, 32'h1234_A5A5, r, n);
        check("R7 notify pulse while held", {16'h0, n}, 32'h0000_A5A5);
        check("R7 no release on notify", {16'h0, r}, 32'h0);
        @(negedge clk);
        check("R7 notify lasts one cycle", {16'h0, notify_evt}, 32'h0);
        bus_write(8'h04, 32'hFFFF_00F3, r, n);
        check("R6 release pulse while held", {16'h0, r}, 32'h0000_00F3);
        @(negedge clk);
        check("R6 release lasts one cycle", {16'h0, release_evt}, 32'h0);
        bus_read(8'h1C, d); check("R5 lock freed", {31'h0, d[31]}, 32'h0);
        bus_write(8'h04, 32'h0000_FFFF, r, n);
        check("R6 no release when free", {16'h0, r}, 32'h0);
        bus_write(8'h08, 32'h0000_8001, r, n);
        check("R7 notify while free", {16'h0, n}, 32'h0000_8001);
    endtask

    task automatic t_reacquire_zero_release;
        logic [31:0] d;
        logic [15:0] r, n;
        set_attr(1'b0, 1'b1, 8'h3E, 12'hABC);
        bus_read(8'h00, d); check("R2 second winner", d, exp_word(1, 0, 1, 8'h3E, 12'hABC));
        bus_write(8'h04, 32'h0, r, n);
        check("R6 zero data no pulse", {16'h0, r}, 32'h0);
        bus_read(8'h1C, d); check("R5 zero write frees", {31'h0, d[31]}, 32'h0);
        bus_read(8'h00, d); check("R5 free again for acquire", {31'h0, d[31]}, 32'h1);
    endtask

    task automatic t_data_words;
        logic [31:0] d;
        logic [15:0] r, n;
        bus_write(8'h0C, 32'hDEAD_BEEF, r, n);
        bus_write(8'h10, 32'h0BAD_F00D, r, n);
        bus_read(8'h0C, d); check("R9 data0", d, 32'hDEAD_BEEF);
        bus_read(8'h10, d); check("R9 data1", d, 32'h0BAD_F00D);
        bus_write(8'h0C, 32'h1, r, n);
        bus_read(8'h10, d); check("R9 data1 independent", d, 32'h0BAD_F00D);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        #(5.0 * 100000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        set_attr(1'b0, 1'b0, 8'h0, 12'h0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_acquire_contention();
        t_write_only_regs();
        t_notify_and_release();
        t_reacquire_zero_release();
        t_data_words();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule